// File: doc/BRIEF.md
# Processor Reset Stretcher with Strap Drive

This block turns a platform reset into the reset seen by the processor. The processor reset output (active low) follows the platform reset while that input is asserted. When the platform reset is released, the processor reset stays asserted for a further interval of bus clocks, set by a parameter. Roughly 1 ms is the usual target, so the default is 100000 clocks at 100 MHz.

While the processor reset is asserted, the block drives a configuration strap pin low through an output enable. The processor samples that pin when its reset goes inactive. The strap is therefore held for a setup window before the release and for a hold window after it. The block then drops the output enable so the pin floats. A completion flag rises when the strap has been let go.

The platform reset passes through a two-flop synchronizer that asserts at once and releases on the clock. Asserting the platform reset again at any point restarts the whole sequence.

Top module: `cpurst_strap_seq`

## Requirements
- R1: While `plat_rst_n` is 0, `cpu_rst_n` is 0, `strap_oe` is 1, `strap_o` is 0 and `seq_done` is 0. These values appear without waiting for a clock edge.
- R2: Count clock edges from the first edge after `plat_rst_n` rises. `cpu_rst_n` goes to 1 on edge STRETCH_CYCLES+3: two edges for the synchronizer, one to start the count, then STRETCH_CYCLES edges.
- R3: On every cycle in which `cpu_rst_n` is 0, `strap_oe` is 1 and `strap_o` is 0. At least SETUP_MIN (4) such cycles precede the rise of `cpu_rst_n`.
- R4: `strap_oe` falls exactly HOLD_CYCLES edges after `cpu_rst_n` rises. HOLD_CYCLES must lie in 2 to 20 and is checked at elaboration; it defaults to 4. The drive window after the release is never shorter than 2 or longer than 20 cycles.
- R5: `seq_done` rises on the same edge on which `strap_oe` falls, and then stays at 1 until the platform reset is asserted again.
- R6: Asserting `plat_rst_n` during the stretch interval returns all outputs to the R1 values. After the next release the full R2 timing applies again.
- R7: Asserting `plat_rst_n` during the hold window forces `cpu_rst_n` back to 0 at once, with the strap driven again.
- R8: Once `cpu_rst_n` has risen, it stays at 1 until `plat_rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| plat_rst_n | input | 1 | Platform reset, active low, asynchronous |
| cpu_rst_n | output | 1 | Processor reset, active low |
| strap_o | output | 1 | Strap drive value (STRAP_LEVEL, 0 by default) |
| strap_oe | output | 1 | Strap output enable; 0 floats the pin |
| seq_done | output | 1 | Strap released; sequence complete |

## Verification
Two instances run side by side. One has a long stretch and the default hold. The other has the minimum stretch and the maximum hold of 20. This shows whether the counters are off by one at either bound.

A design that miscounts would move the release edge or the strap release by a cycle, and the edge-exact measurements would catch this. A design that handled re-assertion poorly would leave the processor out of reset, or leave the strap floating, after a platform reset arrives mid-sequence. The bench also checks that the strap is never dropped while the processor reset is still asserted, and that the completion flag matches the output-enable edge.

// File: rtl/cpurst_pkg.sv
package cpurst_pkg;
    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_STRETCH = 2'd1,
        ST_HOLD    = 2'd2,
        ST_DONE    = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       cpu_rst_n;
        logic       strap_oe;
        logic       done;
    } seq_regs_t;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 (
    input  logic clk,
    input  logic arst_n,
    output logic rst_ok
);
    logic [1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 2'b00;
        else         sync_q <= sync_d;
    end

    assign rst_ok = sync_q[1];
endmodule

// File: rtl/seq_downcnt.sv
module seq_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                cnt_d = load_val;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/cpurst_strap_seq.sv
module cpurst_strap_seq #(
    parameter int   STRETCH_CYCLES = 100000,
    parameter int   SETUP_MIN      = 4,
    parameter int   HOLD_CYCLES    = 4,
    parameter logic STRAP_LEVEL    = 1'b0
) (
    input  logic clk,
    input  logic plat_rst_n,
    output logic cpu_rst_n,
    output logic strap_o,
    output logic strap_oe,
    output logic seq_done
);
    import cpurst_pkg::*;

    localparam int MAX_CNT = (STRETCH_CYCLES > HOLD_CYCLES) ? STRETCH_CYCLES : HOLD_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] STRETCH_LOAD = CNT_W'(STRETCH_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD    = CNT_W'(HOLD_CYCLES - 1);

    generate
        if (HOLD_CYCLES < 2 || HOLD_CYCLES > 20) begin : g_bad_hold
            $error("HOLD_CYCLES must be within 2..20");
        end
        if (STRETCH_CYCLES < SETUP_MIN) begin : g_bad_stretch
            $error("STRETCH_CYCLES must cover the strap setup window");
        end
    endgenerate

    logic            rst_ok;
    logic            cnt_zero;
    logic            cnt_load;
    logic [CNT_W-1:0] cnt_val;
    seq_regs_t       r_d, r_q;

    rst_sync2 u_sync (
        .clk    (clk),
        .arst_n (plat_rst_n),
        .rst_ok (rst_ok)
    );

    seq_downcnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .arst_n   (plat_rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .is_zero  (cnt_zero)
    );

    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_val  = STRETCH_LOAD;
        if (!rst_ok) begin
            r_d.state = ST_RESET;
        end else begin
            unique case (r_q.state)
                ST_RESET: begin
                    r_d.state = ST_STRETCH;
                    cnt_load  = 1'b1;
                    cnt_val   = STRETCH_LOAD;
                end
                ST_STRETCH: begin
                    if (cnt_zero) begin
                        r_d.state = ST_HOLD;
                        cnt_load  = 1'b1;
                        cnt_val   = HOLD_LOAD;
                    end
                end
                ST_HOLD: begin
                    if (cnt_zero) r_d.state = ST_DONE;
                end
                ST_DONE: r_d.state = ST_DONE;
                default: r_d.state = ST_RESET;
            endcase
        end
        r_d.cpu_rst_n = (r_d.state == ST_HOLD) || (r_d.state == ST_DONE);
        r_d.strap_oe  = (r_d.state != ST_DONE);
        r_d.done      = (r_d.state == ST_DONE);
    end

    always_ff @(posedge clk or negedge plat_rst_n) begin
        if (!plat_rst_n) begin
            r_q.state     <= ST_RESET;
            r_q.cpu_rst_n <= 1'b0;
            r_q.strap_oe  <= 1'b1;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_rst_n = r_q.cpu_rst_n;
    assign strap_oe  = r_q.strap_oe;
    assign strap_o   = STRAP_LEVEL;
    assign seq_done  = r_q.done;
endmodule

// File: rtl/cpurst_strap_chk.sv
module cpurst_strap_chk #(
    parameter int SETUP_MIN = 4
) (
    input logic clk,
    input logic plat_rst_n,
    input logic cpu_rst_n,
    input logic strap_o,
    input logic strap_oe,
    input logic seq_done
);
    logic [7:0] setup_cnt;
    logic [7:0] hold_cnt;

    always_ff @(posedge clk or negedge plat_rst_n) begin
        if (!plat_rst_n) begin
            setup_cnt <= '0;
            hold_cnt  <= '0;
        end else begin
            if (!cpu_rst_n && strap_oe && setup_cnt != 8'hFF) setup_cnt <= setup_cnt + 1'b1;
            if (cpu_rst_n && strap_oe && hold_cnt != 8'hFF)   hold_cnt  <= hold_cnt + 1'b1;
        end
    end

    assert_strap_in_rst_R3: assert property (@(posedge clk) disable iff (!plat_rst_n)
        !cpu_rst_n |-> (strap_oe && strap_o == 1'b0));

    assert_setup_window_R3: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $rose(cpu_rst_n) |-> (setup_cnt >= 8'(SETUP_MIN)));

    assert_hold_max_R4: assert property (@(posedge clk) disable iff (!plat_rst_n)
        (cpu_rst_n && strap_oe) |-> (hold_cnt <= 8'd20));

    assert_hold_min_R4: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $fell(strap_oe) |-> (cpu_rst_n && $past(cpu_rst_n) && $past(cpu_rst_n, 2)));

    assert_done_float_R5: assert property (@(posedge clk) disable iff (!plat_rst_n)
        seq_done |-> !strap_oe);

    assert_rst_no_fall_R8: assert property (@(posedge clk) disable iff (!plat_rst_n)
        cpu_rst_n |=> cpu_rst_n);
endmodule

bind cpurst_strap_seq cpurst_strap_chk #(.SETUP_MIN(SETUP_MIN)) u_chk (
    .clk        (clk),
    .plat_rst_n (plat_rst_n),
    .cpu_rst_n  (cpu_rst_n),
    .strap_o    (strap_o),
    .strap_oe   (strap_oe),
    .seq_done   (seq_done)
);

// File: tb/cpurst_strap_seq_tb_top.sv
module cpurst_strap_seq_tb_top;
    localparam int S_A = 12;
    localparam int H_A = 4;
    localparam int S_B = 4;
    localparam int H_B = 20;

    logic clk = 1'b0;
    logic plat_rst_n = 1'b1;
    logic rst_a, so_a, oe_a, dn_a;
    logic rst_b, so_b, oe_b, dn_b;
    int   n_chk = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;

    cpurst_strap_seq #(.STRETCH_CYCLES(S_A), .HOLD_CYCLES(H_A)) dut_i (
        .clk(clk), .plat_rst_n(plat_rst_n), .cpu_rst_n(rst_a),
        .strap_o(so_a), .strap_oe(oe_a), .seq_done(dn_a));

    cpurst_strap_seq #(.STRETCH_CYCLES(S_B), .HOLD_CYCLES(H_B)) dut_b (
        .clk(clk), .plat_rst_n(plat_rst_n), .cpu_rst_n(rst_b),
        .strap_o(so_b), .strap_oe(oe_b), .seq_done(dn_b));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_reset_vals(input string req);
        check({req, " cpu_rst_n A"}, rst_a, 0);
        check({req, " strap_oe A"}, oe_a, 1);
        check({req, " strap_o A"}, so_a, 0);
        check({req, " seq_done A"}, dn_a, 0);
        check({req, " cpu_rst_n B"}, rst_b, 0);
        check({req, " strap_oe B"}, oe_b, 1);
        check({req, " seq_done B"}, dn_b, 0);
    endtask

    // Release platform reset and time both instances, edges counted from release.
    task automatic release_and_measure(input string tag);
        int rise_a = -1, fall_a = -1, rise_b = -1, fall_b = -1;
        int bad_setup = 0, refall = 0, done_mis = 0, setup_a = 0;
        @(negedge clk);
        plat_rst_n = 1'b1;
        for (int cyc = 1; cyc <= 40; cyc++) begin
            @(posedge clk);
            #1;
            if (!rst_a && !(oe_a && so_a == 1'b0)) bad_setup++;
            if (!rst_b && !(oe_b && so_b == 1'b0)) bad_setup++;
            if (!rst_a) setup_a++;
            if (rise_a >= 0 && !rst_a) refall++;
            if (rise_b >= 0 && !rst_b) refall++;
            if (rise_a < 0 && rst_a) rise_a = cyc;
            if (rise_b < 0 && rst_b) rise_b = cyc;
            if (fall_a < 0 && !oe_a) fall_a = cyc;
            if (fall_b < 0 && !oe_b) fall_b = cyc;
            if (dn_a == oe_a) done_mis++;
            if (dn_b == oe_b) done_mis++;
        end
        check({tag, " R2 release edge A"}, rise_a, S_A + 3);
        check({tag, " R2 release edge B"}, rise_b, S_B + 3);
        check({tag, " R3 strap driven in reset"}, bad_setup, 0);
        check({tag, " R3 setup cycles >=4 A"}, int'(setup_a >= 4), 1);
        check({tag, " R4 hold length A"}, fall_a - rise_a, H_A);
        check({tag, " R4 hold length B"}, fall_b - rise_b, H_B);
        check({tag, " R5 done tracks oe"}, done_mis, 0);
        check({tag, " R8 no re-entry to reset"}, refall, 0);
    endtask

    task automatic test_reset_state();
        plat_rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check_reset_vals("R1 reset");
    endtask

    task automatic test_restart();
        // Mid-sequence: A in stretch, B in hold window.
        @(negedge clk);
        plat_rst_n = 1'b1;
        repeat (8) @(posedge clk);
        #1;
        check("R7 B in hold before reassert", rst_b, 1);
        check("R6 A still in stretch", rst_a, 0);
        plat_rst_n = 1'b0;
        #0.5;
        check_reset_vals("R6/R7 async reassert");
        repeat (3) @(posedge clk);
        release_and_measure("restart");
    endtask

    task automatic test_reassert_after_done();
        plat_rst_n = 1'b0;
        #0.5;
        check_reset_vals("R1 reassert after done");
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #2;
        test_reset_state();
        release_and_measure("first");
        test_reassert_after_done();
        test_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule